// File: doc/BRIEF.md
# Bit-Addressed Raster Access Engine

This block connects a 16-bit host data port to a small monochrome bitmap stored as 16-bit words. A host access is not a plain word transfer. Each read or write covers a string of up to sixteen pixels. The string begins at any pixel position and runs either along a row to the right or down a column. The start pixel is the word picked by the host address, shifted right by a 4-bit displacement. A write merges host bits into the bitmap through a selectable Boolean function, and only the first n pixels of the string change. A read returns the string packed into one word.

A write-only mode register sets the direction, the displacement, the write count and the merge function. A shadow of that register can be read back. The engine splits every string into word-sized read-modify-write operations:

- one operation for an aligned horizontal string;
- two operations for a horizontal string that crosses a word boundary;
- sixteen operations for a vertical string, one per row.

`host_busy` stays high until all operations of an access are done. The bitmap holds ROW_WORDS words per row and ROWS rows. Word address a sits at row a / ROW_WORDS and word column a mod ROW_WORDS. Word w of a row holds pixel columns 16w to 16w+15, and data bit 15 is the leftmost pixel of the word.

Top module: `raster_string_engine`

## Requirements
- R1: `host_reg`=1 selects the mode register and `host_reg`=0 selects the bitmap. The mode register fields are:
  - bit 15: horizontal direction (1 = rightward, 0 = downward);
  - bits 14:12: reserved, always stored as 0 whatever is written;
  - bits 11:8: write count;
  - bits 7:4: merge function;
  - bits 3:0: displacement.
  A register read returns the stored value while bit 15 is 1 and bits 3:0 are 0.
- R2: Reset and a one-cycle `mode_reset` pulse both load the mode register with 0x8090. Reset also clears every bitmap pixel to 0. When `mode_reset` and a register write fall in the same cycle, `mode_reset` wins.
- R3: A register read returns 0x0000 while bit 15 is 0 or bits 3:0 are non-zero.
- R4: In horizontal mode, string pixel i (i = 0..15) is at column 16*wc + disp + i of row r. Here r is the row and wc the word column of the host address. Host data bit 15-i belongs to pixel i.
- R5: In vertical mode, string pixel i is at column 16*wc + disp of row r + i.
- R6: A write changes only string pixels i < n. Here n is 16 when the write count is 0, and n equals the count otherwise. Other pixels keep their value.
- R7: The merge function code maps as follows, with s the host bit and d the old pixel:
  - 0 gives 0;
  - 1 gives s AND d;
  - 2 gives s AND NOT d;
  - 3 gives NOT s;
  - 4 gives s OR d;
  - 5 gives s OR NOT d;
  - 6 gives s XOR d;
  - 7 gives NOT d;
  - 8 gives 1;
  - 9 and 10 to 15 give s.
- R8: A bitmap access returns, in `host_rdata`, the string pixels as they were before the access, with bit 15-i holding pixel i. The write count and the merge function do not affect what a read returns, and reads never change the bitmap.
- R9: String pixels whose column or row lies outside the bitmap read as 0 and are never written. The string does not wrap to the next row or to row 0.
- R10: A request is accepted when `host_req` is 1 and `host_busy` is 0, and it is ignored while `host_busy` is 1.
  - A bitmap access keeps `host_busy` high for a fixed number of cycles after acceptance:
    - 1 cycle for horizontal with displacement 0;
    - 2 cycles for horizontal with non-zero displacement;
    - 16 cycles for vertical.
  - `host_done` pulses with valid `host_rdata` in the cycle after `host_busy` falls.
  - A register access raises no busy cycles and pulses `host_done` in the cycle after acceptance. A register write returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| mode_reset | input | 1 | Reloads the mode register with its reset value |
| host_req | input | 1 | Access request |
| host_reg | input | 1 | 1 = mode register, 0 = bitmap |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address (row, word column) |
| host_wdata | input | 16 | Write data; bit 15 is the start pixel |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read result, valid with host_done |

## Verification
The embedded assertions check the following on every clock:
- a mode reload always yields 0x8090;
- a register write stores its value with the reserved bits cleared;
- a read operation and an out-of-range operation leave the addressed word as it was;
- an aligned replace-mode write stores the host word unchanged;
- busy never lasts beyond sixteen cycles;
- done never overlaps busy.

Only the bench scenarios can show the rest. That covers pixel placement for displaced, straddling and vertical strings, the effect of each write count and each merge code, clipping at the right and bottom edges, and whether shadow reads are gated. It also covers requests that arrive while busy having no effect on the bitmap. The reference model compares all of this cycle by cycle.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam logic [15:0] MODE_RESET = 16'h8090;
  localparam logic [15:0] MODE_KEEP  = 16'h8FFF;  // reserved bits 14:12 dropped

  typedef struct packed {
    logic       horiz;  // bit 15
    logic [2:0] rsv;    // bits 14:12
    logic [3:0] cnt;    // bits 11:8
    logic [3:0] fn;     // bits 7:4
    logic [3:0] disp;   // bits 3:0
  } mode_t;

  typedef enum logic [3:0] {
    FN_CLEAR = 4'h0, FN_AND  = 4'h1, FN_ANDN = 4'h2, FN_NOTS = 4'h3,
    FN_OR    = 4'h4, FN_ORN  = 4'h5, FN_XOR  = 4'h6, FN_INVD = 4'h7,
    FN_SET   = 4'h8, FN_COPY = 4'h9
  } fn_e;

  // merge of source bit s into destination bit d
  function automatic logic combine(logic [3:0] fn, logic s, logic d);
    case (fn)
      FN_CLEAR: return 1'b0;
      FN_AND:   return s & d;
      FN_ANDN:  return s & ~d;
      FN_NOTS:  return ~s;
      FN_OR:    return s | d;
      FN_ORN:   return s | ~d;
      FN_XOR:   return s ^ d;
      FN_INVD:  return ~d;
      FN_SET:   return 1'b1;
      default:  return s;
    endcase
  endfunction

  // number of string pixels a write may change
  function automatic logic [4:0] span_len(logic [3:0] cnt);
    return (cnt == 4'd0) ? 5'd16 : {1'b0, cnt};
  endfunction

  // index of the final word operation of a bitmap access
  function automatic logic [3:0] last_op(mode_t m);
    if (!m.horiz)           return 4'd15;
    else if (m.disp == 4'd0) return 4'd0;
    else                    return 4'd1;
  endfunction

endpackage

// File: rtl/raster_mode_reg.sv
module raster_mode_reg
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_reset,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output mode_t       mode_q,
  output logic [15:0] shadow_rd
);

  logic [15:0] mode_bits;
  logic        shadow_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= mode_t'(MODE_RESET);
    else if (mode_reset) mode_q <= mode_t'(MODE_RESET);
    else if (wr_en)      mode_q <= mode_t'(wr_data & MODE_KEEP);
  end

  assign mode_bits = mode_q;
  assign shadow_ok = mode_q.horiz && (mode_q.disp == 4'd0);
  assign shadow_rd = shadow_ok ? mode_bits : 16'h0000;

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reset |=> (mode_bits == 16'h8090)); // R2

  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_reset) |=> (mode_bits == {$past(wr_data[15]), 3'b000, $past(wr_data[11:0])})); // R1

endmodule

// File: rtl/raster_word_op.sv
module raster_word_op
  import raster_pkg::*;
#(
  parameter int ROW_WORDS = 4,
  parameter int ROWS      = 32,
  parameter int RBW       = 5,
  parameter int CBW       = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op,
  input  logic [RBW-1:0] row,
  input  logic [CBW-1:0] wc,
  input  mode_t          mode,
  input  logic [15:0]    wdata,
  input  logic           is_write,
  input  logic [15:0]    rd_word,
  output logic [RBW-1:0] tgt_row,
  output logic [CBW-1:0] tgt_col,
  output logic           tgt_ok,
  output logic [15:0]    wr_word,
  output logic [15:0]    rd_bits
);

  always_comb begin
    int r, c, p, col;
    logic hit;
    logic [4:0] n;
    r       = int'(row) + (mode.horiz ? 0 : int'(op));
    c       = int'(wc) + (mode.horiz ? int'(op) : 0);
    tgt_ok  = (r < ROWS) && (c < ROW_WORDS);
    tgt_row = RBW'(r);
    tgt_col = CBW'(c);
    n       = span_len(mode.cnt);
    wr_word = rd_word;
    rd_bits = 16'h0000;
    for (int i = 0; i < 16; i++) begin
      p   = int'(mode.disp) + i;
      hit = mode.horiz ? ((p >> 4) == int'(op)) : (i == int'(op));
      col = mode.horiz ? (p & 15) : int'(mode.disp);
      if (hit && tgt_ok) begin
        rd_bits[4'(15 - i)] = rd_word[4'(15 - col)];
        if (is_write && (i < int'(n)))
          wr_word[4'(15 - col)] = combine(mode.fn, wdata[4'(15 - i)], rd_word[4'(15 - col)]);
      end
    end
  end

  AST_READ_PURE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_write |-> (wr_word == rd_word)); // R8

  AST_EDGE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_ok |-> (wr_word == rd_word && rd_bits == 16'h0000)); // R9

endmodule

// File: rtl/raster_bitmap.sv
module raster_bitmap #(
  parameter int WORDS = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);

  logic [15:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'h0000;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/raster_string_engine.sv
module raster_string_engine
  import raster_pkg::*;
#(
  parameter int ROW_WORDS = 4,   // power of two, at least 2
  parameter int ROWS      = 32,  // power of two
  localparam int CBW      = $clog2(ROW_WORDS),
  localparam int RBW      = $clog2(ROWS),
  localparam int AW       = CBW + RBW,
  localparam int WORDS    = ROW_WORDS * ROWS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_reset,
  input  logic          host_req,
  input  logic          host_reg,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic          host_busy,
  output logic          host_done,
  output logic [15:0]   host_rdata
);

  mode_t          mode_q, cur_mode;
  logic [15:0]    shadow_rd;
  logic           run, done_q, cur_we;
  logic [3:0]     op_q, last_q;
  logic [AW-1:0]  cur_addr;
  logic [15:0]    cur_data, acc, rdata_q;
  logic [4:0]     busy_cnt;

  // named internal events
  logic           accept, reg_wr, op_last, mem_we, tgt_ok;
  logic [RBW-1:0] tgt_row;
  logic [CBW-1:0] tgt_col;
  logic [15:0]    rd_word, wr_word, rd_bits;

  assign accept  = host_req && !run;
  assign reg_wr  = accept && host_reg && host_we;
  assign op_last = run && (op_q == last_q);
  assign mem_we  = run && cur_we && tgt_ok;

  raster_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_reset(mode_reset),
    .wr_en     (reg_wr),
    .wr_data   (host_wdata),
    .mode_q    (mode_q),
    .shadow_rd (shadow_rd)
  );

  raster_word_op #(
    .ROW_WORDS(ROW_WORDS), .ROWS(ROWS), .RBW(RBW), .CBW(CBW)
  ) u_op (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op_q),
    .row     (cur_addr[AW-1:CBW]),
    .wc      (cur_addr[CBW-1:0]),
    .mode    (cur_mode),
    .wdata   (cur_data),
    .is_write(cur_we),
    .rd_word (rd_word),
    .tgt_row (tgt_row),
    .tgt_col (tgt_col),
    .tgt_ok  (tgt_ok),
    .wr_word (wr_word),
    .rd_bits (rd_bits)
  );

  raster_bitmap #(.WORDS(WORDS), .AW(AW)) u_map (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .addr ({tgt_row, tgt_col}),
    .wdata(wr_word),
    .rdata(rd_word)
  );

  // access sequencer: one word read-modify-write per busy cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= '0;
      last_q   <= '0;
      cur_mode <= mode_t'(MODE_RESET);
      cur_we   <= 1'b0;
      cur_addr <= '0;
      cur_data <= '0;
      acc      <= '0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (host_reg) begin
          done_q  <= 1'b1;
          rdata_q <= host_we ? 16'h0000 : shadow_rd;
        end else begin
          run      <= 1'b1;
          op_q     <= '0;
          last_q   <= last_op(mode_q);
          cur_mode <= mode_q;
          cur_we   <= host_we;
          cur_addr <= host_addr;
          cur_data <= host_wdata;
          acc      <= 16'h0000;
        end
      end else if (run) begin
        acc  <= acc | rd_bits;
        op_q <= op_q + 4'd1;
        if (op_last) begin
          run     <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= acc | rd_bits;
        end
      end
    end
  end

  assign host_busy  = run;
  assign host_done  = done_q;
  assign host_rdata = rdata_q;

  // consecutive busy cycles, for the duration bound
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   busy_cnt <= '0;
    else if (run) busy_cnt <= busy_cnt + 5'd1;
    else          busy_cnt <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> (busy_cnt < 5'd16)); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !host_busy); // R10

  AST_ALIGNED_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !host_reg && mode_q.horiz && mode_q.disp == 4'd0) |=> op_last); // R10

  AST_PLAIN_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cur_mode == mode_t'(MODE_RESET)) |-> (wr_word == cur_data)); // R7

endmodule

// File: tb/raster_string_engine_tb_top.sv
module raster_string_engine_tb_top;

  localparam int RW   = 4;
  localparam int ROWS = 32;
  localparam int W    = RW * 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n = 1'b0, mode_reset = 1'b0, req = 1'b0, reg_sel = 1'b0, we = 1'b0;
  logic [6:0]  addr  = '0;
  logic [15:0] wdata = '0;
  wire         busy, done;
  wire  [15:0] rdata;

  raster_string_engine dut_i (
    .clk(clk), .rst_n(rst_n), .mode_reset(mode_reset),
    .host_req(req), .host_reg(reg_sel), .host_we(we),
    .host_addr(addr), .host_wdata(wdata),
    .host_busy(busy), .host_done(done), .host_rdata(rdata)
  );

  int          compared = 0, mismatched = 0, cyc = 0;
  int          rem = 0;
  logic        exp_done = 1'b0;
  logic [15:0] exp_rdata = '0, m_mode = 16'h8090;
  logic        pix [ROWS][W];
  string       tag = "R2";

  function automatic logic fnc(logic [3:0] f, logic s, logic d);
    case (f)
      4'd0: fnc = 1'b0;
      4'd1: fnc = s && d;
      4'd2: fnc = s && !d;
      4'd3: fnc = !s;
      4'd4: fnc = s || d;
      4'd5: fnc = s || !d;
      4'd6: fnc = s != d;
      4'd7: fnc = !d;
      4'd8: fnc = 1'b1;
      default: fnc = s;
    endcase
  endfunction

  // behavioural string access on the pixel array
  task automatic model_pixel(logic w, int a, logic [15:0] d, logic [15:0] m, output logic [15:0] r);
    int row, wc, n;
    row = a / RW;
    wc  = a % RW;
    n   = (m[11:8] == 0) ? 16 : int'(m[11:8]);
    r   = '0;
    for (int i = 0; i < 16; i++) begin
      int x, y;
      x = wc * 16 + int'(m[3:0]) + (m[15] ? i : 0);
      y = row + (m[15] ? 0 : i);
      if (x < W && y < ROWS) begin
        r[15 - i] = pix[y][x];
        if (w && i < n) pix[y][x] = fnc(m[7:4], d[15 - i], pix[y][x]);
      end
    end
  endtask

  task automatic report_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rem = 0; exp_done = 1'b0; m_mode = 16'h8090;
      for (int y = 0; y < ROWS; y++)
        for (int x = 0; x < W; x++) pix[y][x] = 1'b0;
    end else begin
      exp_done = 1'b0;
      if (rem > 0) begin
        rem--;
        if (rem == 0) exp_done = 1'b1;
      end else if (req) begin
        if (reg_sel) begin
          exp_done  = 1'b1;
          exp_rdata = we ? 16'h0000 : ((m_mode[15] && m_mode[3:0] == 0) ? m_mode : 16'h0000);
          if (we) m_mode = wdata & 16'h8FFF;
        end else begin
          model_pixel(we, int'(addr), wdata, m_mode, exp_rdata);
          rem = !m_mode[15] ? 16 : ((m_mode[3:0] == 0) ? 1 : 2);
        end
      end
      if (mode_reset) m_mode = 16'h8090;
    end
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL R10: watchdog, got no completion expected completion");
      report_and_end();
    end
  end

  task automatic check(string t, logic [15:0] act, logic [15:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", t, act, expv, cyc);
    end
  endtask

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", {15'd0, busy}, {15'd0, rem > 0});
      check("R10", {15'd0, done}, {15'd0, exp_done});
      if (exp_done) check(tag, rdata, exp_rdata);
    end
  end

  task automatic wait_idle();
    while (rem > 0 || exp_done) @(negedge clk);
  endtask

  task automatic access(logic r, logic w, int a, logic [15:0] d);
    @(negedge clk);
    req = 1'b1; reg_sel = r; we = w; addr = 7'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
  endtask

  function automatic logic [15:0] mk(logic h, logic [3:0] cnt, logic [3:0] f, logic [3:0] disp);
    return {h, 3'b000, cnt, f, disp};
  endfunction

  task automatic set_mode(logic [15:0] m);
    access(1'b1, 1'b1, 0, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset value of the mode register via shadow read
    tag = "R2"; access(1'b1, 1'b0, 0, 0);
    tag = "R4"; access(1'b0, 1'b0, 5, 0);  // cleared bitmap reads zero
    // R3: gated shadow read, R1: reserved bits dropped
    tag = "R3"; set_mode(16'hF5A3); access(1'b1, 1'b0, 0, 0);
    set_mode(16'h05A0); access(1'b1, 1'b0, 0, 0);
    tag = "R1"; set_mode(16'hF0A0); access(1'b1, 1'b0, 0, 0);
    // R2: reload command
    tag = "R2";
    @(negedge clk); mode_reset = 1'b1; @(negedge clk); mode_reset = 1'b0;
    access(1'b1, 1'b0, 0, 0);
    // R4: aligned and displaced horizontal strings
    tag = "R4";
    access(1'b0, 1'b1, 5, 16'hBEEF); access(1'b0, 1'b0, 5, 0);
    set_mode(mk(1, 0, 9, 5)); access(1'b0, 1'b1, 9, 16'h1234);
    access(1'b0, 1'b0, 9, 0);
    set_mode(16'h8090); access(1'b0, 1'b0, 9, 0); access(1'b0, 1'b0, 10, 0);
    // R9: string crossing the right edge
    tag = "R9";
    set_mode(mk(1, 0, 9, 8)); access(1'b0, 1'b1, 7, 16'hFFFF);
    access(1'b0, 1'b0, 7, 0);
    set_mode(16'h8090); access(1'b0, 1'b0, 7, 0); access(1'b0, 1'b0, 8, 0);
    // R5: vertical strings
    tag = "R5";
    set_mode(mk(0, 0, 9, 6)); access(1'b0, 1'b1, 2, 16'hA5C3);
    access(1'b0, 1'b0, 2, 0);
    set_mode(16'h8090);
    for (int k = 0; k < 4; k++) access(1'b0, 1'b0, 2 + 4 * k, 0);
    // R9: vertical string running past the last row
    tag = "R9";
    set_mode(mk(0, 0, 9, 15)); access(1'b0, 1'b1, 97, 16'hFFFF);
    access(1'b0, 1'b0, 97, 0);
    // R6: write counts
    tag = "R6";
    set_mode(mk(1, 1, 9, 0)); access(1'b0, 1'b1, 20, 16'hFFFF);
    set_mode(mk(1, 7, 9, 3)); access(1'b0, 1'b1, 24, 16'hFFFF);
    set_mode(mk(0, 15, 9, 0)); access(1'b0, 1'b1, 28, 16'hFFFF);
    set_mode(16'h8090);
    access(1'b0, 1'b0, 20, 0); access(1'b0, 1'b0, 24, 0); access(1'b0, 1'b0, 25, 0);
    set_mode(mk(0, 0, 9, 0)); access(1'b0, 1'b0, 28, 0);
    // R7: every merge code
    tag = "R7";
    for (int f = 0; f < 16; f++) begin
      set_mode(16'h8090); access(1'b0, 1'b1, 60, 16'h0FF0);
      set_mode(mk(1, 0, 4'(f), 0)); access(1'b0, 1'b1, 60, 16'h3C3C);
      set_mode(16'h8090); access(1'b0, 1'b0, 60, 0);
    end
    // R8: count and merge code do not alter reads; write returns old pixels
    tag = "R8";
    set_mode(mk(1, 3, 0, 0)); access(1'b0, 1'b0, 5, 0);
    access(1'b0, 1'b1, 5, 16'h0000);
    set_mode(16'h8090); access(1'b0, 1'b0, 5, 0);
    // R10: requests while busy are ignored
    tag = "R10";
    set_mode(mk(0, 0, 9, 2));
    @(negedge clk); req = 1'b1; reg_sel = 1'b0; we = 1'b0; addr = 7'd8;
    @(negedge clk); we = 1'b1; addr = 7'd0; wdata = 16'hFFFF; reg_sel = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    wait_idle();
    access(1'b1, 1'b0, 0, 0);   // mode unchanged: vertical, gated shadow reads 0
    set_mode(16'h8090); access(1'b0, 1'b0, 0, 0);
    repeat (3) @(negedge clk);
    report_and_end();
  end

endmodule